// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store built from a small array of registers. A stack pointer register always holds the address of the item currently on top. Two 1-bit status registers report when the stack can take no more items and when it holds none. The client raises a push request together with a data word to add an item. It raises a pop request to remove the top item, and the removed word appears on a registered output one cycle later.

The pointer moves up before a push writes and moves down after a pop reads. Address 0 is therefore the last slot to fill: the pointer wraps from the highest address back to 0 on the final push. The flags are updated from that wrap and from the pointer reaching 0 on a pop; they are not compared against an item count. Requests that would overflow or underflow are dropped, and so is a cycle that asks for both operations at once.

Top module: `reg_stack`

## Requirements
- R1: While rst_ni is low and after its release, sp_o is 0, empty_o is 1, full_o is 0 and pop_data_o is 0.
- R2: An accepted push (push_i=1, pop_i=0, full_o=0) raises sp_o by one, modulo 64, at the clock edge. The word is stored at that new address and empty_o goes to 0.
- R3: An accepted pop (pop_i=1, push_i=0, empty_o=0) loads pop_data_o at the clock edge with the word at the address sp_o held before the edge, then lowers sp_o by one, modulo 64.
- R4: Items come back in reverse order of insertion. After three pushes from reset, sp_o reads 3.
- R5: The push that wraps sp_o from 63 to 0 sets full_o to 1, with 64 items stored. full_o and empty_o are never 1 together.
- R6: A pop that brings sp_o to 0 sets empty_o to 1. Any accepted pop clears full_o.
- R7: A push while full_o is 1 is ignored. sp_o, both flags and the stored items stay unchanged, so the next pop still returns the 64th item pushed.
- R8: A pop while empty_o is 1 is ignored. sp_o, both flags and pop_data_o stay unchanged.
- R9: A cycle with push_i and pop_i both at 1 is ignored. sp_o, both flags, pop_data_o and the stored items stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request |
| push_data_i | input | WIDTH | Word to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | WIDTH | Last popped word, registered |
| sp_o | output | $clog2(DEPTH) | Stack pointer, address of the top item |
| full_o | output | 1 | Stack holds DEPTH items |
| empty_o | output | 1 | Stack holds no items |

## Verification
The hardest state to reach is the full stack. It needs 64 accepted pushes in a row, which makes the pointer wrap to 0 so that full and empty could be confused if the flags were wrong. The stimulus fills the stack with distinct words and then pushes again while full. It then drains every item and checks the reverse order, including the item stored at address 0. It also pops once more past empty, then issues simultaneous requests and random mixed traffic. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } stack_op_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic             rd_en_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] ZERO = '0;

  stack_op_e        op;
  logic [PTR_W-1:0] sp_q, sp_inc, sp_dec;
  logic             full_q, empty_q;

  always_comb begin
    unique case ({pop_i, push_i})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
  end

  assign sp_inc    = sp_q + ONE;
  assign sp_dec    = sp_q - ONE;
  assign wr_en_o   = (op == OP_PUSH) && !full_q;
  assign rd_en_o   = (op == OP_POP) && !empty_q;
  assign wr_addr_o = sp_inc;
  assign rd_addr_o = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= ZERO;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (wr_en_o) begin
      sp_q    <= sp_inc;
      full_q  <= (sp_inc == ZERO);
      empty_q <= 1'b0;
    end else if (rd_en_o) begin
      sp_q    <= sp_dec;
      full_q  <= 1'b0;
      empty_q <= (sp_dec == ZERO);
    end
  end

  assign sp_o    = sp_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;

  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + ONE) && !empty_o);
  // R3
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) - ONE) && !full_o);
  // R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  // R5
  full_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (sp_o == ZERO));
  // R6
  empty_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (sp_o == ZERO));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> $stable(sp_o) && full_o);
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> $stable(sp_o) && empty_o);
  // R9
  clash_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o));
endmodule

// File: rtl/stack_mem.sv
module stack_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [WIDTH-1:0] rd_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == PTR_W'(i));
    always_ff @(posedge clk_i) begin
      if (sel) slot_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= slot_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R9
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
endmodule

// File: rtl/reg_stack.sv
module reg_stack #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o
);
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (push_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (pop_data_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (sp_o == '0) && empty_o && !full_o);
endmodule

// File: tb/tb_reg_stack.sv
module tb_reg_stack;
  localparam int DEPTH = 64;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             push = 1'b0, pop = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic [5:0]       sp;
  logic             full, empty;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [WIDTH-1:0] q[$];
  int               m_sp = 0;
  bit               m_full = 0, m_empty = 1;
  logic [WIDTH-1:0] m_dout = '0;

  always #10 clk = ~clk;

  reg_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push), .push_data_i(din),
    .pop_i(pop), .pop_data_o(dout), .sp_o(sp), .full_o(full), .empty_o(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(int'(sp) == m_sp, {req, " sp"}, int'(sp), m_sp);
    check(full == m_full, {req, " full"}, int'(full), int'(m_full));
    check(empty == m_empty, {req, " empty"}, int'(empty), int'(m_empty));
    check(dout == m_dout, {req, " data"}, int'(dout), int'(m_dout));
  endtask

  // inputs change at negedge; model updates at posedge; compare at next negedge
  task automatic cyc(input bit p, input bit o, input logic [WIDTH-1:0] d, input string req);
    push = p; pop = o; din = d;
    @(posedge clk);
    if (p && !o && !m_full) begin
      q.push_back(d);
      m_sp = (m_sp + 1) % DEPTH;
      m_full = (m_sp == 0);
      m_empty = 0;
    end else if (o && !p && !m_empty) begin
      m_dout = q.pop_back();
      m_sp = (m_sp + DEPTH - 1) % DEPTH;
      m_empty = (m_sp == 0);
      m_full = 0;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R4: three pushes, pointer reads 3, reverse order on pops
    cyc(1, 0, 16'h00A1, "R2");
    cyc(1, 0, 16'h00B2, "R2");
    cyc(1, 0, 16'h00C3, "R4");
    check(int'(sp) == 3, "R4 sp after three", int'(sp), 3);
    cyc(0, 1, '0, "R3");
    check(dout == 16'h00C3, "R4 first pop", int'(dout), 'hC3);
    cyc(0, 0, '0, "R3 hold");
    cyc(0, 1, '0, "R4");
    cyc(0, 1, '0, "R6");
    check(empty == 1'b1, "R6 empty at zero", int'(empty), 1);

    // R8: pop while empty
    cyc(0, 1, '0, "R8");
    cyc(0, 1, '0, "R8");

    // R5: fill all 64
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, WIDTH'(16'h1000 + i), "R5");
    check(full == 1'b1 && int'(sp) == 0, "R5 full wrap", int'(full), 1);

    // R7: push while full
    cyc(1, 0, 16'hDEAD, "R7");
    cyc(1, 0, 16'hBEEF, "R7");
    cyc(0, 1, '0, "R7");
    check(dout == WIDTH'(16'h1000 + DEPTH - 1), "R7 top kept", int'(dout), 16'h1000 + DEPTH - 1);
    check(full == 1'b0, "R6 full cleared", int'(full), 0);

    // R9: clash while partially filled
    cyc(1, 1, 16'h5555, "R9");
    cyc(1, 1, 16'hAAAA, "R9");

    // R6: drain the rest
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 1, '0, "R6");
    check(dout == 16'h1000, "R6 last item", int'(dout), 'h1000);

    // R9: clash while empty
    cyc(1, 1, 16'h7777, "R9");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cyc(r < 6, (r >= 4), WIDTH'($urandom), "R2 mixed");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule